// File: doc/BRIEF.md
# Fault Interrupt Status Controller

This block gathers three fault sources into a sticky three-bit status word. The sources are an undervoltage on the logic supply, an undervoltage on the main supply, and an over-temperature warning. It drives an active-low interrupt line and an active-high undervoltage flag from that word. Its inputs are digitized comparator flags: a below-threshold flag for each supply, a hot flag that is true above the warning level, and a cool flag that is true below the lower release level. All four flags pass through a two-stage synchronizer before any logic uses them. A second word mirrors the present condition of each source. Software clears the status word with a one-cycle read strobe.

Each supply fault latches its status bit on the rising edge of its synchronized flag. The over-temperature source is guarded by a two-state re-arm machine. In state `OT_ARMED`, a synchronized hot flag raises a one-cycle set pulse and takes the transition ARM_TO_LATCH into `OT_LATCHED`. In `OT_LATCHED` no further over-temperature set can happen. The machine returns to `OT_ARMED` only through the transition LATCH_TO_ARM, which is taken when the synchronized cool flag is seen. The interrupt from the logic-supply source can be masked with an enable input. The main-supply and over-temperature sources cannot be masked.

Top module: `fault_irq_ctrl`

## Requirements
- R1: During and right after reset, status_o and cond_o are 3'b000, irq_no is 1 and uv_o is 0.
- R2: Status and condition bit positions: bit 0 is over-temperature, bit 1 is main-supply undervoltage, bit 2 is logic-supply undervoltage.
- R3: A rise of lsup_low_i sets status_o[2]. While that flag stays high, cond_o[2] is 1, and cond_o[2] returns to 0 when the flag drops.
- R4: status_o[2] pulls irq_no low only while lsup_mon_en_i is 1. With the enable at 0, that bit alone leaves irq_no at 1.
- R5: uv_o is 1 while status_o[2], lsup_mon_en_i and cond_o[2] are all 1. It falls after cond_o[2] clears, even when status_o[2] stays set.
- R6: A rise of msup_low_i sets status_o[1] and cond_o[1], and that bit always pulls irq_no low.
- R7: In OT_ARMED, a high temp_hot_i sets cond_o[0] and status_o[0], and irq_no goes low. cond_o[0] stays 1 until temp_cool_i is seen.
- R8: A cycle with rd_stb_i high clears all three status bits at the next edge. irq_no returns to 1 one edge after that, provided no new set happened.
- R9: After the over-temperature bit is cleared, toggling temp_hot_i without temp_cool_i in between does not set it again. A cool indication moves the machine to OT_ARMED, and the next hot then sets it.
- R10: When a set and a read strobe fall in the same cycle, the bit being set ends at 1 and the other bits are cleared.
- R11: A status bit appears three rising edges after its input changes (two synchronizer stages plus the status register). irq_no follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lsup_low_i | input | 1 | Logic supply below threshold (asynchronous) |
| msup_low_i | input | 1 | Main supply below threshold (asynchronous) |
| temp_hot_i | input | 1 | Die above warning level (asynchronous) |
| temp_cool_i | input | 1 | Die below release level (asynchronous) |
| rd_stb_i | input | 1 | Status read strobe, one cycle per read |
| lsup_mon_en_i | input | 1 | Enable for the logic-supply interrupt and flag |
| status_o | output | 3 | Sticky status word (bit 0 temp, bit 1 main, bit 2 logic) |
| cond_o | output | 3 | Present condition word, same bit layout |
| irq_no | output | 1 | Interrupt, active low |
| uv_o | output | 1 | Logic-supply undervoltage flag, active high |

## Verification
A new fault set and a status read can land on the same clock edge. The bench provokes this with the over-temperature bit already latched. It raises the main-supply flag and times the read strobe so that the strobe is sampled on the edge where the synchronized rise reaches the status register. That edge must leave only bit 1 set, with bit 0 cleared. irq_no must then stay low, because the surviving bit still drives the interrupt.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
    localparam int NUM_FAULTS = 3;
    localparam int OT_BIT     = 0;
    localparam int MSUP_BIT   = 1;
    localparam int LSUP_BIT   = 2;

    // Indices into the synchronized comparator vector
    localparam int NUM_RAW    = 4;
    localparam int RAW_LSUP   = 0;
    localparam int RAW_MSUP   = 1;
    localparam int RAW_HOT    = 2;
    localparam int RAW_COOL   = 3;

    typedef logic [NUM_FAULTS-1:0] fault_vec_t;

    typedef enum logic {
        OT_ARMED   = 1'b0,
        OT_LATCHED = 1'b1
    } ot_state_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/ot_rearm_fsm.sv
module ot_rearm_fsm
    import fault_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hot_i,
    input  logic cool_i,
    output logic set_o
);
    ot_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= OT_ARMED;
        else         state_q <= state_d;
    end

    // Next state: ARM_TO_LATCH on hot, LATCH_TO_ARM on cool
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OT_ARMED:   if (hot_i)  state_d = OT_LATCHED;
            OT_LATCHED: if (cool_i) state_d = OT_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        set_o = 1'b0;
        unique case (state_q)
            OT_ARMED:   set_o = hot_i;
            OT_LATCHED: set_o = 1'b0;
        endcase
    end

    AST_OT_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_o |=> !set_o); // R9
    AST_OT_HOLD_UNTIL_COOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == OT_LATCHED && !cool_i) |=> (state_q == OT_LATCHED && !set_o)); // R9
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import fault_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lsup_lvl_i,
    input  logic       msup_lvl_i,
    input  logic       hot_i,
    input  logic       cool_i,
    input  logic       ot_set_i,
    input  logic       rd_i,
    input  logic       lsup_en_i,
    output fault_vec_t status_o,
    output fault_vec_t cond_o,
    output logic       irq_no,
    output logic       uv_o
);
    fault_vec_t status_q, status_d, cond_q, cond_d, set_vec, irq_mask;
    logic       lsup_prev_q, msup_prev_q;
    logic       lsup_rise, msup_rise;
    logic       irq_q, uv_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lsup_prev_q <= 1'b0;
            msup_prev_q <= 1'b0;
        end else begin
            lsup_prev_q <= lsup_lvl_i;
            msup_prev_q <= msup_lvl_i;
        end
    end

    assign lsup_rise = lsup_lvl_i & ~lsup_prev_q;
    assign msup_rise = msup_lvl_i & ~msup_prev_q;

    always_comb begin
        set_vec           = '0;
        set_vec[OT_BIT]   = ot_set_i;
        set_vec[MSUP_BIT] = msup_rise;
        set_vec[LSUP_BIT] = lsup_rise;
    end

    // Read clears; a set in the same cycle wins
    always_comb begin
        status_d = (status_q & ~{NUM_FAULTS{rd_i}}) | set_vec;
    end

    always_comb begin
        cond_d           = cond_q;
        cond_d[LSUP_BIT] = lsup_lvl_i;
        cond_d[MSUP_BIT] = msup_lvl_i;
        if (hot_i)       cond_d[OT_BIT] = 1'b1;
        else if (cool_i) cond_d[OT_BIT] = 1'b0;
    end

    always_comb begin
        irq_mask           = '1;
        irq_mask[LSUP_BIT] = lsup_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= '0;
            cond_q   <= '0;
            irq_q    <= 1'b1;
            uv_q     <= 1'b0;
        end else begin
            status_q <= status_d;
            cond_q   <= cond_d;
            irq_q    <= ~|(status_q & irq_mask);
            uv_q     <= status_q[LSUP_BIT] & lsup_en_i & cond_q[LSUP_BIT];
        end
    end

    assign status_o = status_q;
    assign cond_o   = cond_q;
    assign irq_no   = irq_q;
    assign uv_o     = uv_q;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (status_q == '0 && cond_q == '0 && irq_q && !uv_q)); // R1
    AST_LSUP_SETS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsup_rise |=> (status_q[LSUP_BIT] && cond_q[LSUP_BIT])); // R3
    AST_UV_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cond_q[LSUP_BIT] |=> !uv_q); // R5
    AST_HOT_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hot_i |=> cond_q[OT_BIT]); // R7
    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && set_vec == '0) |=> (status_q == '0)); // R8
    AST_SET_WINS_OT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && ot_set_i) |=> status_q[OT_BIT]); // R10
    AST_SET_WINS_MSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && msup_rise) |=> status_q[MSUP_BIT]); // R10
    AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lsup_rise || msup_rise) |=> !(lsup_rise && $past(lsup_rise)) && !(msup_rise && $past(msup_rise))); // R11
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
    import fault_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  lsup_low_i,
    input  logic                  msup_low_i,
    input  logic                  temp_hot_i,
    input  logic                  temp_cool_i,
    input  logic                  rd_stb_i,
    input  logic                  lsup_mon_en_i,
    output logic [NUM_FAULTS-1:0] status_o,
    output logic [NUM_FAULTS-1:0] cond_o,
    output logic                  irq_no,
    output logic                  uv_o
);
    logic [NUM_RAW-1:0] raw_vec, sync_vec;
    logic               ot_set;

    always_comb begin
        raw_vec           = '0;
        raw_vec[RAW_LSUP] = lsup_low_i;
        raw_vec[RAW_MSUP] = msup_low_i;
        raw_vec[RAW_HOT]  = temp_hot_i;
        raw_vec[RAW_COOL] = temp_cool_i;
    end

    fault_sync #(.WIDTH(NUM_RAW), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_vec),
        .level_o (sync_vec)
    );

    ot_rearm_fsm u_ot_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hot_i  (sync_vec[RAW_HOT]),
        .cool_i (sync_vec[RAW_COOL]),
        .set_o  (ot_set)
    );

    fault_status_reg u_status (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lsup_lvl_i (sync_vec[RAW_LSUP]),
        .msup_lvl_i (sync_vec[RAW_MSUP]),
        .hot_i      (sync_vec[RAW_HOT]),
        .cool_i     (sync_vec[RAW_COOL]),
        .ot_set_i   (ot_set),
        .rd_i       (rd_stb_i),
        .lsup_en_i  (lsup_mon_en_i),
        .status_o   (status_o),
        .cond_o     (cond_o),
        .irq_no     (irq_no),
        .uv_o       (uv_o)
    );

    AST_LSUP_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == 3'b100 && !lsup_mon_en_i) |=> irq_no); // R4
    AST_MSUP_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[MSUP_BIT] |=> !irq_no); // R6
    AST_OT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[OT_BIT] |=> !irq_no); // R7
endmodule

// File: tb/fault_irq_ctrl_tb.sv
module fault_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       lsup = 1'b0, msup = 1'b0, hot = 1'b0, cool = 1'b0;
    logic       rd = 1'b0, en = 1'b0;
    logic [2:0] status, cond;
    logic       irq_n, uv;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic [2:0] cd;
        logic       irq;
        logic       uvf;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    fault_irq_ctrl u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .lsup_low_i    (lsup),
        .msup_low_i    (msup),
        .temp_hot_i    (hot),
        .temp_cool_i   (cool),
        .rd_stb_i      (rd),
        .lsup_mon_en_i (en),
        .status_o      (status),
        .cond_o        (cond),
        .irq_no        (irq_n),
        .uv_o          (uv)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_out(input logic [2:0] st, input logic [2:0] cd,
                              input logic irq, input logic uvf, input string tag);
        exp_t e;
        e.st = st; e.cd = cd; e.irq = irq; e.uvf = uvf; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic read_pulse();
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
    endtask

    // Monitor: compares a popped item shortly after the driver's negedge
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            e = q.pop_front();
            #1;
            n_vec++;
            if (status !== e.st || cond !== e.cd || irq_n !== e.irq || uv !== e.uvf) begin
                n_bad++;
                $display("FAIL %s: got st=%b cd=%b irq_n=%b uv=%b, expected st=%b cd=%b irq_n=%b uv=%b",
                         e.tag, status, cond, irq_n, uv, e.st, e.cd, e.irq, e.uvf);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(3);
        expect_out(3'b000, 3'b000, 1'b1, 1'b0, "R1 in reset");
        tick(1);
        rst_ni = 1'b1;
        tick(2);
        expect_out(3'b000, 3'b000, 1'b1, 1'b0, "R1 after reset");

        // R6, R2, R11: main supply, bit 1, latency
        msup = 1'b1;
        tick(2);
        expect_out(3'b000, 3'b000, 1'b1, 1'b0, "R11 not before third edge");
        tick(1);
        expect_out(3'b010, 3'b010, 1'b1, 1'b0, "R6 R2 main bit set");
        tick(1);
        expect_out(3'b010, 3'b010, 1'b0, 1'b0, "R11 irq one edge later");
        // R8: read clears
        read_pulse();
        expect_out(3'b000, 3'b010, 1'b0, 1'b0, "R8 status cleared");
        tick(1);
        expect_out(3'b000, 3'b010, 1'b1, 1'b0, "R8 irq released");
        msup = 1'b0;
        tick(3);
        expect_out(3'b000, 3'b000, 1'b1, 1'b0, "R6 cond follows input");

        // R3, R4: logic supply with monitor disabled
        lsup = 1'b1;
        tick(3);
        expect_out(3'b100, 3'b100, 1'b1, 1'b0, "R3 R4 logic bit, masked");
        tick(2);
        expect_out(3'b100, 3'b100, 1'b1, 1'b0, "R4 stays masked");
        en = 1'b1;
        tick(1);
        expect_out(3'b100, 3'b100, 1'b0, 1'b1, "R4 R5 enabled irq and uv");
        lsup = 1'b0;
        tick(3);
        expect_out(3'b100, 3'b000, 1'b0, 1'b1, "R3 cond cleared, uv pending");
        tick(1);
        expect_out(3'b100, 3'b000, 1'b0, 1'b0, "R5 uv drops on recovery");
        read_pulse();
        tick(1);
        expect_out(3'b000, 3'b000, 1'b1, 1'b0, "R8 logic bit cleared");

        // R7, R9: over-temperature and re-arm
        hot = 1'b1;
        tick(3);
        expect_out(3'b001, 3'b001, 1'b1, 1'b0, "R7 R2 temp bit set");
        tick(1);
        expect_out(3'b001, 3'b001, 1'b0, 1'b0, "R7 irq asserted");
        read_pulse();
        tick(1);
        expect_out(3'b000, 3'b001, 1'b1, 1'b0, "R8 temp cleared");
        hot = 1'b0;
        tick(4);
        expect_out(3'b000, 3'b001, 1'b1, 1'b0, "R7 cond held without cool");
        hot = 1'b1;
        tick(4);
        expect_out(3'b000, 3'b001, 1'b1, 1'b0, "R9 no re-set without cool");
        hot = 1'b0;
        cool = 1'b1;
        tick(3);
        expect_out(3'b000, 3'b000, 1'b1, 1'b0, "R7 cool clears cond");
        cool = 1'b0;
        hot = 1'b1;
        tick(3);
        expect_out(3'b001, 3'b001, 1'b1, 1'b0, "R9 re-armed set");
        tick(1);
        expect_out(3'b001, 3'b001, 1'b0, 1'b0, "R9 irq after re-arm");

        // R10: main-supply set and read on the same edge
        msup = 1'b1;
        tick(2);
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        expect_out(3'b010, 3'b011, 1'b0, 1'b0, "R10 set beats clear");
        tick(1);
        expect_out(3'b010, 3'b011, 1'b0, 1'b0, "R10 irq held by survivor");
        read_pulse();
        expect_out(3'b000, 3'b011, 1'b0, 1'b0, "R8 second read");
        tick(1);
        expect_out(3'b000, 3'b011, 1'b1, 1'b0, "R8 irq released again");

        tick(2);
        wait (q.size() == 0);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule